// File: doc/BRIEF.md
# Selectable Binary-Fraction Random Bit Source

This block emits one random bit per enabled clock cycle. The chance that the bit is 1 is J/2^N, where J is an N-bit selector that may change on any cycle. The block holds N free-running pseudo-random sources, each giving a fair bit per cycle. It feeds those bits through a chain of N stages, one for each selector bit. A stage whose selector bit is 0 ANDs its fresh fair bit with the result so far. This acts like a random switch in series and halves the probability, putting a 0 at the top of the binary fraction. A stage whose selector bit is 1 ORs its fair bit in. This acts like a random switch in parallel and puts a 1 at the top of the fraction.

The chain starts at the least significant selector bit. The first stage gates its random bit with selector bit 0. So J = 0 gives a stream of zeros, and as J counts up the chance steps through every N-bit binary fraction in increasing order. The result is registered, and a valid flag marks the cycles that carry a fresh sample.

Top module: `stoch_frac_gen`

## Requirements
- R1: While `rst_n` is low, `rbit` and `rvalid` are both 0.
- R2: `rvalid` is 1 in the cycle after a rising clock edge where `en` was 1, and 0 in the cycle after an edge where `en` was 0.
- R3: After a clock edge where `en` was 0, `rbit` is 0.
- R4: After an edge where `en` was 1 and `sel` was 0, `rbit` is 0. A run with `sel` = 0 holds no ones.
- R5: With `en` held at 1 and `sel` = J held constant, the share of ones in `rbit` is J/2^N within a statistical tolerance. With N = 4 and 8192 samples, the expected count is J·512 ± 200.
- R6: A new `sel` value takes effect on the very next output. The first sample after `sel` drops from all-ones to 0 is already 0.
- R7: No random source ever reaches the all-zero state. So for J = 8, which gives a chance of 1/2, a run holds both zeros and ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Take a sample and advance the sources this cycle |
| sel | input | SEL_W | Selector J; the chance of a one is J/2^SEL_W |
| rbit | output | 1 | Registered random output bit |
| rvalid | output | 1 | `rbit` holds a sample taken on the previous edge |

## Verification
Each result is due one clock edge after the inputs that set it, since there is exactly one register between `en`/`sel` and `rbit`/`rvalid`. The bench drives inputs on the falling edge and samples on the next falling edge. This way each sample reflects exactly the rising edge in between. For the statistical runs, the count of ones starts at the first falling edge after the new selector is applied. It stops after a fixed number of samples, so no sample from the previous selector is counted. The zero-selector and selector-change checks also sample that first edge directly.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

   // Galois feedback masks (right-shifting form) for maximal-length LFSRs
   function automatic logic [31:0] sfg_taps(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // Distinct nonzero seed per source index
   function automatic logic [31:0] sfg_seed(input int idx, input int w);
      logic [31:0] s;
      logic [31:0] m;
      s = 32'hACE1_2F5B ^ (32'(idx + 1) * 32'h9E37_79B1);
      s = s ^ (s >> 13);
      m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      s = s & m;
      if (s == 32'd0) s = 32'd1;
      return s;
   endfunction

endpackage

// File: rtl/sfg_lfsr.sv
module sfg_lfsr #(
   parameter int          LFSR_W = 16,
   parameter logic [31:0] SEED   = 32'h0000_0001
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic rnd
);
   import sfg_pkg::*;

   localparam logic [31:0]       TAPS_ALL = sfg_taps(LFSR_W);
   localparam logic [LFSR_W-1:0] TAPS     = TAPS_ALL[LFSR_W-1:0];
   localparam logic [LFSR_W-1:0] INIT     = SEED[LFSR_W-1:0];

   generate
      if (TAPS_ALL == 32'd0) begin : g_bad_width
         $error("sfg_lfsr: unsupported LFSR_W");
      end
      if (INIT == '0) begin : g_bad_seed
         $error("sfg_lfsr: seed must be nonzero");
      end
   endgenerate

   logic [LFSR_W-1:0] state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= INIT;
      end else if (step) begin
         state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
      end
   end

   assign rnd = state[0];

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0); // R7

endmodule

// File: rtl/sfg_chain.sv
module sfg_chain #(
   parameter int SEL_W = 4
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [SEL_W-1:0] rnd,
   output logic             hit
);
   logic [SEL_W-1:0] node;

   // Stage 0: gated random switch, the only place a zero chance arises
   assign node[0] = sel[0] & rnd[0];

   generate
      for (genvar i = 1; i < SEL_W; i++) begin : g_stage
         // selector bit 1: parallel (OR), selector bit 0: series (AND)
         assign node[i] = sel[i] ? (rnd[i] | node[i-1]) : (rnd[i] & node[i-1]);
      end
   endgenerate

   assign hit = node[SEL_W-1];

   always_comb begin
      if (sel[SEL_W-1] && rnd[SEL_W-1]) begin
         AST_TOP_PARALLEL_CLOSED: assert (hit); // R5
      end
      if (!sel[SEL_W-1] && !rnd[SEL_W-1]) begin
         AST_TOP_SERIES_OPEN: assert (!hit); // R5
      end
   end

endmodule

// File: rtl/stoch_frac_gen.sv
module stoch_frac_gen #(
   parameter int SEL_W  = 4,
   parameter int LFSR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             rbit,
   output logic             rvalid
);
   import sfg_pkg::*;

   generate
      if (SEL_W < 1 || SEL_W > 24) begin : g_bad_sel
         $error("stoch_frac_gen: SEL_W out of range");
      end
   endgenerate

   logic [SEL_W-1:0] rnd;
   logic             hit;

   generate
      for (genvar i = 0; i < SEL_W; i++) begin : g_src
         localparam logic [31:0] SEED_I = sfg_seed(i, LFSR_W);
         sfg_lfsr #(
            .LFSR_W (LFSR_W),
            .SEED   (SEED_I)
         ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (en),
            .rnd   (rnd[i])
         );
      end
   endgenerate

   sfg_chain #(
      .SEL_W (SEL_W)
   ) u_chain (
      .sel (sel),
      .rnd (rnd),
      .hit (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbit   <= 1'b0;
         rvalid <= 1'b0;
      end else begin
         rbit   <= en & hit;
         rvalid <= en;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (!rbit && !rvalid)); // R1
   AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> rvalid); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rvalid && !rbit)); // R3
   AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sel == '0) |=> !rbit); // R4

endmodule

// File: tb/stoch_frac_gen_test.sv
module stoch_frac_gen_test;

   localparam int SEL_W   = 4;
   localparam int SAMPLES = 8192;
   localparam int TOL     = 200;
   localparam int NVEC    = 16;
   localparam logic [SEL_W-1:0] VEC_SEL [NVEC] = '{
      4'd0, 4'd15, 4'd1, 4'd8, 4'd7, 4'd14, 4'd2, 4'd9,
      4'd4, 4'd12, 4'd3, 4'd11, 4'd6, 4'd13, 4'd5, 4'd10
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [SEL_W-1:0] sel = '0;
   logic             rbit;
   logic             rvalid;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   stoch_frac_gen #(.SEL_W(SEL_W), .LFSR_W(16)) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .sel    (sel),
      .rbit   (rbit),
      .rvalid (rvalid)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #1_900_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(rbit == 1'b0, "R1 rbit in reset", int'(rbit), 0);
      check(rvalid == 1'b0, "R1 rvalid in reset", int'(rvalid), 0);

      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(rvalid == 1'b0, "R2 rvalid idle", int'(rvalid), 0);
      check(rbit == 1'b0, "R3 rbit idle", int'(rbit), 0);

      // R2: valid one edge after enable
      en  = 1'b1;
      sel = 4'd15;
      @(negedge clk);
      check(rvalid == 1'b1, "R2 rvalid after en", int'(rvalid), 1);

      // R5 / R4 / R7: table of selectors, one loop
      for (int k = 0; k < NVEC; k++) begin
         int ones;
         int expc;
         ones = 0;
         sel  = VEC_SEL[k];
         expc = int'(VEC_SEL[k]) * (SAMPLES >> SEL_W);
         for (int s = 0; s < SAMPLES; s++) begin
            @(negedge clk);
            ones += int'(rbit);
         end
         if (VEC_SEL[k] == '0) begin
            check(ones == 0, "R4 zero selector count", ones, 0);
         end else begin
            check((ones >= expc - TOL) && (ones <= expc + TOL),
                  $sformatf("R5 count for J=%0d", VEC_SEL[k]), ones, expc);
         end
         if (VEC_SEL[k] == 4'd8) begin
            check((ones > 0) && (ones < SAMPLES), "R7 half chance not stuck", ones, expc);
         end
      end

      // R6: selector change seen on the very next sample
      sel = 4'd15;
      repeat (4) @(negedge clk);
      sel = 4'd0;
      begin
         int seen;
         seen = 0;
         for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            seen += int'(rbit);
         end
         check(seen == 0, "R6 ones after switch to zero", seen, 0);
      end

      // R2 / R3: disable drops valid and bit after one edge
      sel = 4'd15;
      repeat (2) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check(rvalid == 1'b0, "R2 rvalid after disable", int'(rvalid), 0);
      check(rbit == 1'b0, "R3 rbit after disable", int'(rbit), 0);

      // R1: asynchronous reset mid-run
      en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(rvalid == 1'b0, "R1 rvalid async reset", int'(rvalid), 0);
      check(rbit == 1'b0, "R1 rbit async reset", int'(rbit), 0);

      summary();
   end

endmodule